// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 128 pins, grouped as four banks of 32. Pin n is bit n mod 32 of bank n/32. A simple synchronous register port gives software control over each pin. Through it, software sets the pin direction and drives an output latch. The latch is changed only by a write-one-to-set register and a write-one-to-clear register. Software can also read back the level of every pin.

Each input pin passes through a single sampling register. The sampled value is compared with the previous sample on every clock. The rising and falling transitions that this comparison finds can set sticky edge flags, one enable for each direction. Software clears a flag by writing a one to it. Three interrupt lines come from the flags:
- one line for pin 0,
- one line for pin 1,
- one shared line for every other pin.

A fixed mask for each bank selects the input pins that can request a processor wake-up. Each bank also keeps two alternate-function words. These words are storage only and have no effect on the pins.

Read data is registered. It appears in the cycle after the read strobe and holds until the next read. The register map is irregular: the fourth bank of each per-bank register sits 0x100 above its first bank.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all pins are inputs and the pin output-enable and output vectors are zero. Edge enables, edge flags and alternate-function words read zero. All three interrupt lines and the wake output are low.
- R2: Registers are decoded on byte offsets. The per-bank registers have these bank-0 offsets: level 0x000, direction 0x00C, set 0x018, clear 0x024, rising enable 0x030, falling enable 0x03C, edge flags 0x048. Banks 1 and 2 follow at +4 and +8, and bank 3 is at +0x100. Bank k has its low alternate-function word at 0x054+8k and its high word at 0x058+8k. Read data is valid in the cycle after bus_rd and holds otherwise.
- R3: A direction bit of 1 makes the pin an output. pin_oe always equals the direction bits.
- R4: Writing the set register ORs the data into the bank latch. Writing the clear register clears the latch bits that are written as one. Bits written as zero are unchanged. pin_out always equals the latch.
- R5: The level register returns the latch bit for output pins and the sampled pin for input pins. A pin change becomes visible one clock after it is sampled.
- R6: A sampled rising (falling) transition sets a pin's edge flag only when the pin is an input and its rising (falling) enable is 1. The flag rises on the second clock edge after the pin changes.
- R7: Writing ones to the edge-flag register clears those flags, and zero bits leave flags unchanged. When a new edge arrives in the same cycle as a clear of that bit, the flag stays set.
- R8: irq_pin0 follows edge flag 0 of bank 0 and irq_pin1 follows edge flag 1 of bank 0. irq_shared is the OR of every other edge flag in all four banks.
- R9: Reading the set register returns the last value written to it. Reading the clear register returns the constant CLR_RD_VALUE (default 0xBAD00C1E).
- R10: A read at an offset of 0x200 or above, or at any undecoded offset, returns zero. A write there changes no state.
- R11: A sampled transition on an input pin whose wake-mask bit is 1 gives a one-cycle wake_req pulse on the second clock edge after the pin change. Pin 0 is masked and pin 2 is not. Output pins never request wake.
- R12: The alternate-function words store and return the written values and do not affect pin_oe or pin_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | External pin levels |
| pin_out | output | 128 | Output latch to the pads |
| pin_oe | output | 128 | Output enable to the pads (1 = drive) |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
A corrupted direction or latch bit shows on pin_oe or pin_out immediately after the faulty write, because both ports drive straight from those flops. A wrong edge flag or enable shows on an interrupt line exactly two clocks after the pin change. It also persists until software clears it, so both a missing and a spurious flag can be seen at the next read of the flag register. Sampling faults show in the level readback one clock after the pin change and in the width of the wake pulse. Decoder faults show as data returned from, or stored into, the wrong bank or register.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   typedef enum logic [3:0] {
      RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR,
      RK_RISE, RK_FALL, RK_STAT, RK_ALT_LO, RK_ALT_HI
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e   kind;
      logic [1:0]  bank;
   } reg_sel_t;

   localparam int N_BANK_REGS = 7;

   localparam reg_kind_e KIND_TAG [N_BANK_REGS] = '{
      RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_RISE, RK_FALL, RK_STAT
   };

   localparam int KIND_OFS [N_BANK_REGS] = '{
      'h000, 'h00C, 'h018, 'h024, 'h030, 'h03C, 'h048
   };

   localparam int ALT_BASE    = 'h054;
   localparam int ALT_STRIDE  = 8;
   localparam int HIGH_BANK_GAP = 'h100;
   localparam int MAP_LIMIT   = 'h200;

   function automatic int bank_step(input int b);
      return (b == 3) ? HIGH_BANK_GAP : 4 * b;
   endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
   import gpio_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 4
)(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   always_comb begin
      sel.kind = RK_NONE;
      sel.bank = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int r = 0; r < N_BANK_REGS; r++) begin
            if (int'(addr) == KIND_OFS[r] + bank_step(b)) begin
               sel.kind = KIND_TAG[r];
               sel.bank = 2'(b);
            end
         end
         if (int'(addr) == ALT_BASE + ALT_STRIDE * b) begin
            sel.kind = RK_ALT_LO;
            sel.bank = 2'(b);
         end
         if (int'(addr) == ALT_BASE + 4 + ALT_STRIDE * b) begin
            sel.kind = RK_ALT_HI;
            sel.bank = 2'(b);
         end
      end
   end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
   import gpio_ctrl_pkg::*;
#(
   parameter int           W            = 32,
   parameter logic [W-1:0] WAKE_MASK    = '0,
   parameter logic [W-1:0] CLR_RD_VALUE = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  reg_kind_e     kind,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  pin_in,
   output logic [W-1:0]  dir_q,
   output logic [W-1:0]  latch_q,
   output logic [W-1:0]  flag_q,
   output logic [W-1:0]  rd_word,
   output logic          wake_hit
);

   logic [W-1:0] samp_q, prev_q;
   logic [W-1:0] rise_en_q, fall_en_q;
   logic [W-1:0] set_shadow_q, alt_lo_q, alt_hi_q;
   logic [W-1:0] new_edges, clr_mask, level;

   assign new_edges = ((samp_q & ~prev_q & rise_en_q) |
                       (~samp_q & prev_q & fall_en_q)) & ~dir_q;
   assign clr_mask  = (wr_stb && kind == RK_STAT) ? wdata : '0;
   assign level     = (latch_q & dir_q) | (samp_q & ~dir_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q       <= '0;
         prev_q       <= '0;
         dir_q        <= '0;
         latch_q      <= '0;
         rise_en_q    <= '0;
         fall_en_q    <= '0;
         flag_q       <= '0;
         set_shadow_q <= '0;
         alt_lo_q     <= '0;
         alt_hi_q     <= '0;
         wake_hit     <= 1'b0;
      end else begin
         samp_q   <= pin_in;
         prev_q   <= samp_q;
         wake_hit <= |((samp_q ^ prev_q) & ~dir_q & WAKE_MASK);
         // a fresh edge wins over a simultaneous clear
         flag_q   <= (flag_q & ~clr_mask) | new_edges;
         if (wr_stb) begin
            case (kind)
               RK_DIR:    dir_q     <= wdata;
               RK_SET: begin
                  latch_q      <= latch_q | wdata;
                  set_shadow_q <= wdata;
               end
               RK_CLR:    latch_q   <= latch_q & ~wdata;
               RK_RISE:   rise_en_q <= wdata;
               RK_FALL:   fall_en_q <= wdata;
               RK_ALT_LO: alt_lo_q  <= wdata;
               RK_ALT_HI: alt_hi_q  <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (kind)
         RK_LEVEL:  rd_word = level;
         RK_DIR:    rd_word = dir_q;
         RK_SET:    rd_word = set_shadow_q;
         RK_CLR:    rd_word = CLR_RD_VALUE;
         RK_RISE:   rd_word = rise_en_q;
         RK_FALL:   rd_word = fall_en_q;
         RK_STAT:   rd_word = flag_q;
         RK_ALT_LO: rd_word = alt_lo_q;
         RK_ALT_HI: rd_word = alt_hi_q;
         default:   rd_word = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 32,
   localparam int PINS     = NUM_BANKS * BANK_W
)(
   input  logic [PINS-1:0] flags,
   output logic            irq_pin0,
   output logic            irq_pin1,
   output logic            irq_shared
);

   logic [PINS-1:0] rest;

   always_comb begin
      rest       = flags;
      rest[1:0]  = 2'b00;
   end

   assign irq_pin0   = flags[0];
   assign irq_pin1   = flags[1];
   assign irq_shared = |rest;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 32,
   parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK =
      {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B},
   parameter logic [BANK_W-1:0] CLR_RD_VALUE = 32'hBAD00C1E,
   localparam int PINS = NUM_BANKS * BANK_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq_pin0,
   output logic              irq_pin1,
   output logic              irq_shared,
   output logic              wake_req
);

   generate
      if (NUM_BANKS != 4) begin : g_bad_banks
         $error("gpio_edge_ctrl: register map is fixed at four banks");
      end
      if (BANK_W != 32) begin : g_bad_width
         $error("gpio_edge_ctrl: bank width must match the 32-bit data bus");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("gpio_edge_ctrl: address too narrow for the register map");
      end
   endgenerate

   reg_sel_t          sel;
   logic [BANK_W-1:0] bank_rd [NUM_BANKS];
   logic [PINS-1:0]   flags;
   logic [NUM_BANKS-1:0] wake_hits;

   gpio_reg_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_stb;
      assign wr_stb = bus_wr && (sel.kind != RK_NONE) && (int'(sel.bank) == b);

      gpio_bank_slice #(
         .W            (BANK_W),
         .WAKE_MASK    (WAKE_MASK[b*BANK_W +: BANK_W]),
         .CLR_RD_VALUE (CLR_RD_VALUE)
      ) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_stb   (wr_stb),
         .kind     (sel.kind),
         .wdata    (bus_wdata),
         .pin_in   (pin_in[b*BANK_W +: BANK_W]),
         .dir_q    (pin_oe[b*BANK_W +: BANK_W]),
         .latch_q  (pin_out[b*BANK_W +: BANK_W]),
         .flag_q   (flags[b*BANK_W +: BANK_W]),
         .rd_word  (bank_rd[b]),
         .wake_hit (wake_hits[b])
      );
   end

   gpio_irq_merge #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_irq (
      .flags      (flags),
      .irq_pin0   (irq_pin0),
      .irq_pin1   (irq_pin1),
      .irq_shared (irq_shared)
   );

   assign wake_req = |wake_hits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= (sel.kind == RK_NONE) ? '0 : bank_rd[sel.bank];
      end
   end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int ADDR_W = 12,
   parameter int PINS   = 128
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic              irq_pin0,
   input logic              irq_shared,
   input logic              wake_req
);

   // R3: direction only moves because of a register write
   assert_oe_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(bus_wr));

   // R4: the output latch only moves because of a register write
   assert_latch_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(bus_wr));

   // R6: a pin-0 interrupt rises only after that pin was seen to change
   assert_irq0_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pin0) |-> ($past(pin_in[0], 2) != $past(pin_in[0], 3)));

   // R8: the shared interrupt rises only after some pin changed
   assert_shared_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_shared) |-> ($past(pin_in, 2) != $past(pin_in, 3)));

   // R7: flags are removed only by a write
   assert_irq0_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pin0) |-> $past(bus_wr));

   // R10: reads beyond the map return zero
   assert_far_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (int'(bus_addr) >= 'h200)) |=> (bus_rdata == '0));

   // R11: wake pulse follows a pin change
   assert_wake_needs_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(pin_in, 2) != $past(pin_in, 3)));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .pin_in     (pin_in),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq_pin0   (irq_pin0),
   .irq_shared (irq_shared),
   .wake_req   (wake_req)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;

   localparam int PINS = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic [PINS-1:0]   pin_in = '0;
   logic [PINS-1:0]   pin_out, pin_oe;
   logic              irq_pin0, irq_pin1, irq_shared, wake_req;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   gpio_edge_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
      .wake_req(wake_req)
   );

   localparam int O_LVL = 'h000, O_DIR = 'h00C, O_SET = 'h018, O_CLR = 'h024;
   localparam int O_RISE = 'h030, O_FALL = 'h03C, O_STAT = 'h048;

   function automatic int ofs(input int base, input int b);
      return (b == 3) ? base + 'h100 : base + 4 * b;
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = 12'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 pin_oe", pin_oe, '0);
      check("R1 pin_out", pin_out, '0);
      check("R1 irqs", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);
      rd(ofs(O_DIR, 2), v);   check("R1 dir bank2", v, '0);
      rd(ofs(O_STAT, 0), v);  check("R1 flags bank0", v, '0);
      rd(ofs(O_RISE, 3), v);  check("R1 rise en bank3", v, '0);
      rd('h06C, v);           check("R1 alt lo bank3", v, '0);
   endtask

   task automatic t_dir_out();
      logic [31:0] v, dir_w, latch_w, pins_w;
      dir_w = 32'hF0F0_0001; pins_w = 32'h1234_5678;
      pin_in[63:32] = pins_w;
      wr(ofs(O_DIR, 1), dir_w);
      check("R3 pin_oe bank1", pin_oe[63:32], dir_w);
      wr(ofs(O_SET, 1), 32'h0000_00FF);
      check("R4 set bank1", pin_out[63:32], 32'h0000_00FF);
      wr(ofs(O_CLR, 1), 32'h0000_000F);
      latch_w = 32'h0000_00F0;
      check("R4 clear bank1", pin_out[63:32], latch_w);
      wr(ofs(O_SET, 1), 32'h0);
      check("R4 zero set no effect", pin_out[63:32], latch_w);
      wr(ofs(O_SET, 1), 32'h0000_0030);
      rd(ofs(O_SET, 1), v);   check("R9 set readback", v, 32'h0000_0030);
      rd(ofs(O_CLR, 1), v);   check("R9 clear readback", v, 32'hBAD0_0C1E);
      rd(ofs(O_LVL, 1), v);
      check("R5 level mix", v, (latch_w & dir_w) | (pins_w & ~dir_w));
      wr(ofs(O_DIR, 3), 32'h0000_00A5);
      check("R2 bank3 dir at +0x100", pin_oe[127:96], 32'h0000_00A5);
      check("R2 bank2 untouched", pin_oe[95:64], 32'h0);
      // R5: input change visible one clock later
      @(negedge clk); pin_in[33] = 1'b1;
      @(negedge clk);
      rd(ofs(O_LVL, 1), v);
      check("R5 new sample", v[1], 1'b1);
   endtask

   task automatic t_edges();
      logic [31:0] v;
      wr(ofs(O_RISE, 0), 32'h1);
      wr(ofs(O_FALL, 0), 32'h2);
      wr(ofs(O_RISE, 2), 32'h100);
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk);
      check("R6 flag not yet", irq_pin0, 1'b0);
      @(negedge clk);
      check("R6 rise sets flag", irq_pin0, 1'b1);
      @(negedge clk); pin_in[1] = 1'b1;
      repeat (3) @(negedge clk);
      check("R6 rise without enable", irq_pin1, 1'b0);
      pin_in[1] = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 fall pin1 irq", irq_pin1, 1'b1);
      check("R8 shared still low", irq_shared, 1'b0);
      pin_in[72] = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 shared from bank2", irq_shared, 1'b1);
      rd(ofs(O_STAT, 2), v);  check("R6 flag bank2", v, 32'h100);
      wr(ofs(O_STAT, 0), 32'h1);
      check("R7 clear pin0", {irq_pin0, irq_pin1}, 2'b01);
      wr(ofs(O_STAT, 0), 32'h0);
      check("R7 zero write keeps", irq_pin1, 1'b1);
      wr(ofs(O_STAT, 2), 32'h100);
      check("R7 clear shared", irq_shared, 1'b0);
      // output pin does not flag
      wr(ofs(O_DIR, 0), 32'h1);
      @(negedge clk); pin_in[0] = 1'b0;
      repeat (2) @(negedge clk); pin_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      rd(ofs(O_STAT, 0), v);  check("R6 output pin gated", v[0], 1'b0);
      wr(ofs(O_DIR, 0), 32'h0);
      // race: new edge and clear in the same cycle
      @(negedge clk); pin_in[0] = 1'b0;
      repeat (3) @(negedge clk);
      pin_in[0] = 1'b1;
      @(negedge clk);
      bus_addr = 12'(ofs(O_STAT, 0)); bus_wdata = 32'h1; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R7 edge wins over clear", irq_pin0, 1'b1);
      wr(ofs(O_STAT, 0), 32'h3);
      check("R7 final clear", {irq_pin0, irq_pin1}, 2'b00);
   endtask

   task automatic t_wake();
      @(negedge clk); pin_in[2] = 1'b1;
      @(negedge clk); check("R11 unmasked pin a", wake_req, 1'b0);
      @(negedge clk); check("R11 unmasked pin b", wake_req, 1'b0);
      pin_in[0] = 1'b0;
      @(negedge clk); check("R11 not yet", wake_req, 1'b0);
      @(negedge clk); check("R11 pulse", wake_req, 1'b1);
      @(negedge clk); check("R11 one cycle", wake_req, 1'b0);
      wr(ofs(O_DIR, 0), 32'h1);
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); check("R11 output pin no wake", wake_req, 1'b0);
      wr(ofs(O_DIR, 0), 32'h0);
   endtask

   task automatic t_range();
      logic [31:0] v;
      logic [127:0] oe_before;
      oe_before = pin_oe;
      wr('h200 + O_DIR, 32'hFFFF_FFFF);
      wr('h300 + O_DIR, 32'hFFFF_FFFF);
      check("R10 far write ignored", pin_oe, oe_before);
      rd(ofs(O_DIR, 1), v);   check("R2 dir bank1 read", v, 32'hF0F0_0001);
      rd('h200, v);           check("R10 far read zero", v, '0);
      rd(ofs(O_DIR, 1), v);
      rd('h080, v);           check("R10 hole read zero", v, '0);
   endtask

   task automatic t_alt();
      logic [31:0] v;
      logic [127:0] oe_before, out_before;
      oe_before = pin_oe; out_before = pin_out;
      wr('h064, 32'h1111_2222);
      wr('h070, 32'h3333_4444);
      rd('h064, v);  check("R12 alt lo bank2", v, 32'h1111_2222);
      rd('h070, v);  check("R12 alt hi bank3", v, 32'h3333_4444);
      rd('h068, v);  check("R2 alt hi bank2 separate", v, 32'h0);
      check("R12 pins unaffected", {pin_oe, pin_out}, {oe_before, out_before});
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dir_out();
      t_edges();
      t_wake();
      t_range();
      t_alt();
      finish_run();
   end

endmodule